// File: doc/BRIEF.md
# Core Nap and Power-Down Sequencer

This block decides when the clock of a processor core may run. It holds one of three states: running, napping while the core waits on an I/O transfer, and powered down. While napping, only the core clock is held off. The I/O section stays clocked, so the pending transfer can complete. When the I/O side signals that the transfer is done, the core clock returns by itself.

Power-down is requested from outside. The active-high run enable `core_on` is dropped while the sleep flag is high. The request then reaches the state register through a two-flop synchronizer and one stop stage. The core and I/O clock enables therefore fall exactly three clock edges after the enable is first sampled low. They rise again exactly three edges after it is first sampled high. The enable for the serial-interface clock domains is never withdrawn.

A power-down request takes precedence over everything else. If the I/O transfer finishes while the block is entering power-down, or while it is powered down, the completion is remembered. The core then wakes straight into the running state rather than back into a nap.

Top module: `core_nap_ctrl`

## Requirements
- R1: After reset, `state_code` is 0 (running) and `core_clk_en`, `io_clk_en` and `ser_clk_en` are all 1.
- R2: `state_code` encodes the state as 0 = running, 1 = napping, 2 = powered down. `core_clk_en` is 1 only when running. `io_clk_en` is 0 only when powered down.
- R3: If `core_on` is sampled low and `sleep_mode` high on three consecutive rising edges, `state_code` is 2 after the third of those edges and not before it.
- R4: If `sleep_mode` is low, a low `core_on` never leads to power-down.
- R5: Power-down holds for as long as `core_on` stays low.
- R6: After `core_on` is first sampled high, the block stays powered down through two more edges and leaves power-down at the third edge.
- R7: `ser_clk_en` is 1 in every state, including power-down.
- R8: When running, `io_wait` high with `io_done` low at an edge moves the block to napping. When napping, `io_done` high moves it back to running. When running, `io_wait` and `io_done` high together keep it running.
- R9: A power-down request wins over `io_done` in the same cycle. Any `io_done` seen while entering or inside power-down is remembered.
- R10: On wake-up, the block goes to napping if `io_wait` is high and no completion was remembered. Otherwise it goes to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_on | input | 1 | Asynchronous run enable, active high |
| sleep_mode | input | 1 | Sleep flag, synchronous to clk |
| io_wait | input | 1 | Core waits on an I/O event (level) |
| io_done | input | 1 | I/O operation completed (one-cycle pulse) |
| core_clk_en | output | 1 | Core clock enable |
| io_clk_en | output | 1 | I/O section clock enable |
| ser_clk_en | output | 1 | Serial-interface domain enable, never gated |
| state_code | output | 2 | 0 running, 1 napping, 2 powered down |

## Verification
The I/O completion and the power-down entry can fall on the same edge. The bench provokes this while the block is napping: it drops `core_on` with `sleep_mode` high and then pulses `io_done` exactly on the third edge. It judges the result by checking that the block shows 2 at that edge, not 0. Then, with `io_wait` still high, it checks that the block wakes into running (0) rather than napping (1). A control run without the pulse must wake into napping.

// File: rtl/nap_pkg.sv
// Package: shared state encoding for the nap / power-down sequencer.
// Assumes: the encoding is visible at the top-level status port.
package nap_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_NAP  = 2'd1,
        ST_DOWN = 2'd2
    } nap_state_e;
endpackage

// File: rtl/nap_sync.sv
// Module: nap_sync
// Brings an asynchronous level into the clk domain through a flop chain.
// Assumes: STAGES >= 2; the reset value is the level the input is expected to hold.
module nap_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // shift the sampled level one stage per edge
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nap_fsm.sv
// Module: nap_fsm
// State register (the stop stage) and the completion latch.
// Power-down has priority over nap entry/exit; io_done seen on the way into
// or inside power-down is remembered and decides the wake-up target.
// Assumes: on_sync is already synchronous; io_done is a single-cycle pulse.
module nap_fsm
    import nap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       on_sync,
    input  logic       sleep_mode,
    input  logic       io_wait,
    input  logic       io_done,
    output nap_state_e state
);
    nap_state_e state_d;
    logic       pend_q, pend_d;
    logic       down_req;

    // power-down wanted: enable inactive while in sleep mode
    assign down_req = !on_sync && sleep_mode;

    // next-state and completion-latch decision
    always_comb begin
        state_d = state;
        pend_d  = pend_q;
        unique case (state)
            ST_RUN: begin
                pend_d = 1'b0;
                if (down_req)                state_d = ST_DOWN;
                else if (io_wait && !io_done) state_d = ST_NAP;
            end
            ST_NAP: begin
                if (down_req) begin
                    state_d = ST_DOWN;
                    pend_d  = io_done;
                end else if (io_done) begin
                    state_d = ST_RUN;
                    pend_d  = 1'b0;
                end
            end
            ST_DOWN: begin
                if (on_sync) begin
                    pend_d  = 1'b0;
                    state_d = (io_wait && !pend_q && !io_done) ? ST_NAP : ST_RUN;
                end else begin
                    pend_d = pend_q || io_done;
                end
            end
            default: begin
                state_d = ST_RUN;
                pend_d  = 1'b0;
            end
        endcase
    end

    // stop-stage register and latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_RUN;
            pend_q <= 1'b0;
        end else begin
            state  <= state_d;
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/nap_gate.sv
// Module: nap_gate
// Decodes the state into clock enables and the status code.
// Assumes: enables feed external gating cells; the serial domain is exempt.
module nap_gate
    import nap_pkg::*;
(
    input  nap_state_e state,
    output logic       core_clk_en,
    output logic       io_clk_en,
    output logic       ser_clk_en,
    output logic [1:0] state_code
);
    // map the state to the gating scopes
    always_comb begin
        core_clk_en = (state == ST_RUN);
        io_clk_en   = (state != ST_DOWN);
        ser_clk_en  = 1'b1;
        state_code  = state;
    end
endmodule

// File: rtl/core_nap_ctrl.sv
// Module: core_nap_ctrl (top)
// Nap / power-down sequencer: synchronizer, then stop-stage FSM, then enable decode.
// Stop and wake latency is SYNC_STAGES + 1 edges (3 at the default).
// Assumes: sleep_mode is synchronous to clk; core_on may be asynchronous.
module core_nap_ctrl
    import nap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       core_on,
    input  logic       sleep_mode,
    input  logic       io_wait,
    input  logic       io_done,
    output logic       core_clk_en,
    output logic       io_clk_en,
    output logic       ser_clk_en,
    output logic [1:0] state_code
);
    logic       on_sync;
    nap_state_e state;

    nap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(core_on), .sync_out(on_sync)
    );

    nap_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .on_sync(on_sync), .sleep_mode(sleep_mode),
        .io_wait(io_wait), .io_done(io_done), .state(state)
    );

    nap_gate u_gate (
        .state(state), .core_clk_en(core_clk_en), .io_clk_en(io_clk_en),
        .ser_clk_en(ser_clk_en), .state_code(state_code)
    );
endmodule

// File: rtl/core_nap_chk.sv
// Module: core_nap_chk
// Port-level protocol checks for core_nap_ctrl, attached by bind.
// Latency windows are tracked with saturating counters, not deep $past.
module core_nap_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       core_on,
    input logic       sleep_mode,
    input logic       io_wait,
    input logic       io_done,
    input logic       core_clk_en,
    input logic       io_clk_en,
    input logic       ser_clk_en,
    input logic [1:0] state_code
);
    localparam int LAT = SYNC_STAGES + 1;
    localparam int CW  = $clog2(LAT + 1);

    logic [CW-1:0] off_run, on_run, down_run;

    // count consecutive edges with enable low, enable high, and down request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_run <= '0; on_run <= '0; down_run <= '0;
        end else begin
            off_run  <= core_on ? '0 : ((off_run == CW'(LAT)) ? off_run : off_run + 1'b1);
            on_run   <= !core_on ? '0 : ((on_run == CW'(LAT)) ? on_run : on_run + 1'b1);
            down_run <= (core_on || !sleep_mode) ? '0
                      : ((down_run == CW'(LAT)) ? down_run : down_run + 1'b1);
        end
    end

    a_r2_core_only_run: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> state_code == 2'd0);
    a_r2_io_off_only_down: assert property (@(posedge clk) disable iff (!rst_n)
        !io_clk_en |-> state_code == 2'd2);
    a_r3_stop_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (down_run == CW'(LAT)) |-> state_code == 2'd2);
    a_r4_no_down_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != 2'd2 && !sleep_mode) |=> state_code != 2'd2);
    a_r5_down_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd2 && off_run == CW'(LAT)) |=> state_code == 2'd2);
    a_r6_wake_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (on_run == CW'(LAT)) |-> state_code != 2'd2);
    a_r7_serial_free: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk_en);
    a_r8_nap_keeps_io: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 2'd1 |-> (io_clk_en && !core_clk_en));
endmodule

bind core_nap_ctrl core_nap_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .core_on(core_on), .sleep_mode(sleep_mode),
    .io_wait(io_wait), .io_done(io_done), .core_clk_en(core_clk_en),
    .io_clk_en(io_clk_en), .ser_clk_en(ser_clk_en), .state_code(state_code)
);

// File: tb/core_nap_ctrl_test.sv
// Bench for core_nap_ctrl: sweeps sleep flag x start state x hold length,
// plus the completion / power-down collision. Inputs change at negedge,
// outputs are sampled at negedge after a counted number of rising edges.
module core_nap_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_on = 1'b1, sleep_mode = 1'b0, io_wait = 1'b0, io_done = 1'b0;
    logic       core_clk_en, io_clk_en, ser_clk_en;
    logic [1:0] state_code;
    int         checks = 0, failures = 0;
    bit         done_flag = 1'b0;

    core_nap_ctrl uut (
        .clk(clk), .rst_n(rst_n), .core_on(core_on), .sleep_mode(sleep_mode),
        .io_wait(io_wait), .io_done(io_done), .core_clk_en(core_clk_en),
        .io_clk_en(io_clk_en), .ser_clk_en(ser_clk_en), .state_code(state_code)
    );

    always #10 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // compare state code and the enables it implies (R2 encoding, R7)
    task automatic expect_state(input string req, input logic [1:0] exp);
        logic [3:0] got, want;
        got  = {state_code, core_clk_en, io_clk_en};
        want = {exp, exp == 2'd0, exp != 2'd2};
        checks++;
        if (got !== want || ser_clk_en !== 1'b1) begin
            failures++;
            $display("FAIL %s: got code=%0d core=%0b io=%0b ser=%0b, expected code=%0d core=%0b io=%0b ser=1",
                     req, state_code, core_clk_en, io_clk_en, ser_clk_en,
                     exp, exp == 2'd0, exp != 2'd2);
        end
    endtask

    initial begin
        tick(3);
        expect_state("R1 reset", 2'd0);
        rst_n = 1'b1;
        tick(2);
        expect_state("R1 after reset", 2'd0);

        // R8: wait and done together stay running
        io_wait = 1'b1; io_done = 1'b1;
        tick(1);
        expect_state("R8 wait+done in run", 2'd0);
        io_wait = 1'b0; io_done = 1'b0;

        for (int s = 0; s < 2; s++)
            for (int nap = 0; nap < 2; nap++)
                for (int h = 1; h <= 4; h++) begin
                    logic [1:0] prior;
                    prior = nap ? 2'd1 : 2'd0;
                    if (nap != 0) begin
                        io_wait = 1'b1;
                        tick(1);
                        expect_state("R8 nap entry", 2'd1);
                    end
                    sleep_mode = (s != 0);
                    core_on = 1'b0;
                    tick(1); expect_state("R3 edge1 not yet", prior);
                    tick(1); expect_state("R3 edge2 not yet", prior);
                    tick(1); expect_state(s ? "R3 stop at edge3" : "R4 no stop awake", s ? 2'd2 : prior);
                    for (int k = 0; k < h; k++) begin
                        tick(1);
                        expect_state(s ? "R5 hold + R7" : "R4 hold", s ? 2'd2 : prior);
                    end
                    core_on = 1'b1;
                    tick(1); expect_state("R6 wake edge1", s ? 2'd2 : prior);
                    tick(1); expect_state("R6 wake edge2", s ? 2'd2 : prior);
                    tick(1); expect_state("R6 wake edge3 / R10 to nap", prior);
                    sleep_mode = 1'b0;
                    if (nap != 0) begin
                        io_wait = 1'b0; io_done = 1'b1;
                        tick(1);
                        expect_state("R8 nap exit on done", 2'd0);
                        io_done = 1'b0;
                    end
                end

        // R9: collision of done and power-down entry while napping
        io_wait = 1'b1;
        tick(1);
        expect_state("R8 nap before collision", 2'd1);
        sleep_mode = 1'b1; core_on = 1'b0;
        tick(2);
        io_done = 1'b1;
        tick(1);
        expect_state("R9 down wins over done", 2'd2);
        io_done = 1'b0;
        core_on = 1'b1;
        tick(3);
        expect_state("R10 wake to run after remembered done", 2'd0);
        io_wait = 1'b0;
        tick(1);

        // R9: done pulse inside power-down
        io_wait = 1'b1;
        tick(1);
        expect_state("R8 nap again", 2'd1);
        core_on = 1'b0;
        tick(4);
        expect_state("R9 down again", 2'd2);
        io_done = 1'b1;
        tick(1);
        io_done = 1'b0;
        expect_state("R9 done inside down keeps down", 2'd2);
        core_on = 1'b1;
        tick(3);
        expect_state("R10 wake to run after done in down", 2'd0);
        io_wait = 1'b0; sleep_mode = 1'b0;
        tick(1);
        expect_state("R8 stays run", 2'd0);

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule